// File: doc/BRIEF.md
# Register Consumer Table

This block sits between decode and dispatch in an out-of-order core that tracks data dependences with forward pointers instead of broadcast wakeup. It holds one row per architectural register. Each row records the chain tail, which is the most recent queue entry and operand slot that touched the register. It also holds a busy flag and the queue entry of the newest producer. When an instruction is decoded, its source lookups return the tail that dispatch must link to. If a source is not busy, the lookup reports that the value is already in the architectural register file.

Readers and writers both move the tail. A writer starts a fresh chain at its destination slot. A reader of a busy register becomes the new tail at its own source slot. Commit clears a row's busy flag when the committing entry is still that row's newest producer. A single snapshot of the whole table can be captured when a branch is predicted. The snapshot is loaded back on a misprediction, and commits that happen in between are also applied to the snapshot.

Top module: `consumer_table`

## Requirements
- R1: After a synchronous active-low reset, every register is not busy, and every enabled source lookup returns busy 0 with tail entry 0 and tail slot 0. A disabled source lookup always returns all zeros.
- R2: A decode with the destination enabled makes the destination register busy. Its tail becomes (decode entry, slot 0 = destination) and its newest producer becomes the decode entry.
- R3: An enabled source that names a busy register returns busy 1 with that register's current tail. After the cycle, the register's tail is (decode entry, slot 1) for source 1 or (decode entry, slot 2) for source 2.
- R4: An enabled source that names a register that is not busy returns busy 0 and tail zero, and that register's row is not changed.
- R5: When one instruction reads and writes the same register, the source lookup returns the tail from before this instruction, and afterwards the tail is the instruction's destination slot.
- R6: When both sources name the same busy register, source 1 returns the stored tail and source 2 returns (decode entry, slot 1). Afterwards the tail is (decode entry, slot 2).
- R7: A commit of (entry, register) clears that register's busy flag only when the entry equals the register's newest producer. Otherwise the row is unchanged.
- R8: When a commit clear and a new producer hit the same register in the same cycle, the register stays busy with the new producer.
- R9: A checkpoint request captures the table as it stands after that cycle's own decode update. A later restore reloads it, discarding updates made in between.
- R10: In a restore cycle, the decode update is ignored.
- R11: A commit that matches the snapshot's newest producer also clears the busy flag in the snapshot, so that a later restore does not bring back a busy flag that has already retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | A decoded instruction updates the table this cycle |
| dec_entry | input | EW | Queue entry assigned to the decoded instruction |
| src1_en | input | 1 | Source 1 is a register operand |
| src1_reg | input | RW | Source 1 register number |
| src2_en | input | 1 | Source 2 is a register operand |
| src2_reg | input | RW | Source 2 register number |
| dst_en | input | 1 | Instruction writes a register |
| dst_reg | input | RW | Destination register number |
| src1_busy | output | 1 | Source 1 must link to a chain (1) or read the register file (0) |
| src1_tail_entry | output | EW | Queue entry of source 1's chain tail |
| src1_tail_slot | output | 2 | Operand slot of source 1's chain tail (0 dest, 1 src1, 2 src2) |
| src2_busy | output | 1 | Source 2 must link to a chain |
| src2_tail_entry | output | EW | Queue entry of source 2's chain tail |
| src2_tail_slot | output | 2 | Operand slot of source 2's chain tail |
| cmt_valid | input | 1 | A producer commits this cycle |
| cmt_entry | input | EW | Queue entry of the committing producer |
| cmt_reg | input | RW | Register that the committing producer writes |
| ckpt_take | input | 1 | Capture the snapshot |
| ckpt_restore | input | 1 | Reload the table from the snapshot |

## Verification
The hardest cases to reach are the retire-after-checkpoint case and the writer-versus-commit collision. Both need a specific history: a producer must be decoded and captured in the snapshot, then retire, and only after that may the restore come. For the collision, a new producer of the same register must be decoded in exactly the cycle in which the old producer commits. The vector table builds a chain step by step across several registers. It lines up a same-cycle commit and redefinition, and it issues commits with stale and current producer entries. Directed sequences then take a checkpoint, commit the captured producer, restore, and read the register back through a source lookup.

// File: rtl/ct_pkg.sv
// Package: shared slot encoding for the register consumer table.
// Assumes: operand slots fit in two bits; code 3 is never produced.
package ct_pkg;
    typedef enum logic [1:0] {
        SLOT_DST  = 2'd0,
        SLOT_SRC1 = 2'd1,
        SLOT_SRC2 = 2'd2
    } slot_e;
endpackage

// File: rtl/ct_lookup.sv
// Module: ct_lookup
// Resolves the two source lookups of one decoded instruction against the
// current table contents. When both sources name the same busy register,
// source 2 is chained behind source 1 of the same instruction.
// Assumes: table inputs are the registered state, not the next state.
module ct_lookup #(
    parameter int NUM_REGS = 16,
    parameter int EW       = 6,
    parameter int RW       = 4
) (
    input  logic [NUM_REGS-1:0][EW-1:0] tail_entry,
    input  logic [NUM_REGS-1:0][1:0]    tail_slot,
    input  logic [NUM_REGS-1:0]         busy,
    input  logic [EW-1:0]               dec_entry,
    input  logic                        s1_en,
    input  logic [RW-1:0]               s1_reg,
    input  logic                        s2_en,
    input  logic [RW-1:0]               s2_reg,
    output logic                        s1_busy,
    output logic [EW-1:0]               s1_entry,
    output logic [1:0]                  s1_slot,
    output logic                        s2_busy,
    output logic [EW-1:0]               s2_entry,
    output logic [1:0]                  s2_slot
);
    import ct_pkg::*;

    // Source 1: plain table read.
    always_comb begin
        s1_busy  = 1'b0;
        s1_entry = '0;
        s1_slot  = '0;
        if (s1_en && busy[s1_reg]) begin
            s1_busy  = 1'b1;
            s1_entry = tail_entry[s1_reg];
            s1_slot  = tail_slot[s1_reg];
        end
    end

    // Source 2: table read, or link behind source 1 of the same instruction.
    always_comb begin
        s2_busy  = 1'b0;
        s2_entry = '0;
        s2_slot  = '0;
        if (s2_en && s1_en && (s2_reg == s1_reg) && busy[s2_reg]) begin
            s2_busy  = 1'b1;
            s2_entry = dec_entry;
            s2_slot  = SLOT_SRC1;
        end else if (s2_en && busy[s2_reg]) begin
            s2_busy  = 1'b1;
            s2_entry = tail_entry[s2_reg];
            s2_slot  = tail_slot[s2_reg];
        end
    end
endmodule

// File: rtl/ct_row_next.sv
// Module: ct_row_next
// Next-state function of one table row. Precedence, lowest first:
// commit clear, source 1 append, source 2 append, new producer.
// Assumes: hit inputs are already qualified by register match and decode.
module ct_row_next #(
    parameter int EW = 6
) (
    input  logic [EW-1:0] cur_entry,
    input  logic [1:0]    cur_slot,
    input  logic          cur_busy,
    input  logic [EW-1:0] cur_writer,
    input  logic          hit_s1,
    input  logic          hit_s2,
    input  logic          hit_dst,
    input  logic          hit_cmt,
    input  logic [EW-1:0] dec_entry,
    input  logic [EW-1:0] cmt_entry,
    output logic [EW-1:0] nxt_entry,
    output logic [1:0]    nxt_slot,
    output logic          nxt_busy,
    output logic [EW-1:0] nxt_writer
);
    import ct_pkg::*;

    // Apply the row updates in precedence order.
    always_comb begin
        nxt_entry  = cur_entry;
        nxt_slot   = cur_slot;
        nxt_busy   = cur_busy;
        nxt_writer = cur_writer;
        if (hit_cmt && cur_busy && (cur_writer == cmt_entry)) begin
            nxt_busy = 1'b0;
        end
        if (hit_s1) begin
            nxt_entry = dec_entry;
            nxt_slot  = SLOT_SRC1;
        end
        if (hit_s2) begin
            nxt_entry = dec_entry;
            nxt_slot  = SLOT_SRC2;
        end
        if (hit_dst) begin
            nxt_entry  = dec_entry;
            nxt_slot   = SLOT_DST;
            nxt_busy   = 1'b1;
            nxt_writer = dec_entry;
        end
    end
endmodule

// File: rtl/consumer_table.sv
// Module: consumer_table (top)
// Per-register chain-tail table with one checkpoint snapshot.
// Lookups are combinational from the registered table. Updates take effect
// at the next rising edge. Restore overrides decode. Commits act on both
// the live table and the snapshot.
// Assumes: one decoded instruction and one commit per cycle.
module consumer_table #(
    parameter int NUM_REGS    = 16,
    parameter int QUEUE_DEPTH = 64,
    localparam int EW = $clog2(QUEUE_DEPTH),
    localparam int RW = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [EW-1:0] dec_entry,
    input  logic          src1_en,
    input  logic [RW-1:0] src1_reg,
    input  logic          src2_en,
    input  logic [RW-1:0] src2_reg,
    input  logic          dst_en,
    input  logic [RW-1:0] dst_reg,
    output logic          src1_busy,
    output logic [EW-1:0] src1_tail_entry,
    output logic [1:0]    src1_tail_slot,
    output logic          src2_busy,
    output logic [EW-1:0] src2_tail_entry,
    output logic [1:0]    src2_tail_slot,
    input  logic          cmt_valid,
    input  logic [EW-1:0] cmt_entry,
    input  logic [RW-1:0] cmt_reg,
    input  logic          ckpt_take,
    input  logic          ckpt_restore
);
    logic [NUM_REGS-1:0][EW-1:0] live_entry, live_writer, snap_entry, snap_writer;
    logic [NUM_REGS-1:0][1:0]    live_slot, snap_slot;
    logic [NUM_REGS-1:0]         live_busy, snap_busy;

    logic [NUM_REGS-1:0][EW-1:0] upd_entry, upd_writer, sel_entry, sel_writer;
    logic [NUM_REGS-1:0][1:0]    upd_slot, sel_slot;
    logic [NUM_REGS-1:0]         upd_busy, sel_busy, snap_busy_c;

    logic dec_fire;
    assign dec_fire = dec_valid && !ckpt_restore;

    ct_lookup #(.NUM_REGS(NUM_REGS), .EW(EW), .RW(RW)) u_lookup (
        .tail_entry (live_entry),
        .tail_slot  (live_slot),
        .busy       (live_busy),
        .dec_entry  (dec_entry),
        .s1_en      (src1_en),
        .s1_reg     (src1_reg),
        .s2_en      (src2_en),
        .s2_reg     (src2_reg),
        .s1_busy    (src1_busy),
        .s1_entry   (src1_tail_entry),
        .s1_slot    (src1_tail_slot),
        .s2_busy    (src2_busy),
        .s2_entry   (src2_tail_entry),
        .s2_slot    (src2_tail_slot)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
        logic hit_s1, hit_s2, hit_dst, hit_cmt;
        assign hit_s1  = dec_fire && src1_busy && (src1_reg == RW'(r));
        assign hit_s2  = dec_fire && src2_busy && (src2_reg == RW'(r));
        assign hit_dst = dec_fire && dst_en && (dst_reg == RW'(r));
        assign hit_cmt = cmt_valid && (cmt_reg == RW'(r));

        ct_row_next #(.EW(EW)) u_row (
            .cur_entry  (live_entry[r]),
            .cur_slot   (live_slot[r]),
            .cur_busy   (live_busy[r]),
            .cur_writer (live_writer[r]),
            .hit_s1     (hit_s1),
            .hit_s2     (hit_s2),
            .hit_dst    (hit_dst),
            .hit_cmt    (hit_cmt),
            .dec_entry  (dec_entry),
            .cmt_entry  (cmt_entry),
            .nxt_entry  (upd_entry[r]),
            .nxt_slot   (upd_slot[r]),
            .nxt_busy   (upd_busy[r]),
            .nxt_writer (upd_writer[r])
        );

        // Snapshot busy flag after this cycle's retiring producer.
        assign snap_busy_c[r] = snap_busy[r] &&
                                !(hit_cmt && (snap_writer[r] == cmt_entry));

        // Live next state: restored snapshot or normal update.
        always_comb begin
            if (ckpt_restore) begin
                sel_entry[r]  = snap_entry[r];
                sel_slot[r]   = snap_slot[r];
                sel_busy[r]   = snap_busy_c[r];
                sel_writer[r] = snap_writer[r];
            end else begin
                sel_entry[r]  = upd_entry[r];
                sel_slot[r]   = upd_slot[r];
                sel_busy[r]   = upd_busy[r];
                sel_writer[r] = upd_writer[r];
            end
        end
    end

    // Live table register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_entry  <= '0;
            live_slot   <= '0;
            live_busy   <= '0;
            live_writer <= '0;
        end else begin
            live_entry  <= sel_entry;
            live_slot   <= sel_slot;
            live_busy   <= sel_busy;
            live_writer <= sel_writer;
        end
    end

    // Snapshot register: capture next live state, else track commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_entry  <= '0;
            snap_slot   <= '0;
            snap_busy   <= '0;
            snap_writer <= '0;
        end else if (ckpt_take) begin
            snap_entry  <= sel_entry;
            snap_slot   <= sel_slot;
            snap_busy   <= sel_busy;
            snap_writer <= sel_writer;
        end else begin
            snap_busy   <= snap_busy_c;
        end
    end
endmodule

// File: rtl/ct_checker.sv
// Module: ct_checker
// Temporal properties of consumer_table, bound to every instance.
// Assumes: sees the live and snapshot state through the bind.
module ct_checker #(
    parameter int NUM_REGS = 16,
    parameter int EW       = 6,
    parameter int RW       = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        dec_valid,
    input logic [EW-1:0]               dec_entry,
    input logic                        src1_en,
    input logic [RW-1:0]               src1_reg,
    input logic                        src1_busy,
    input logic                        src2_en,
    input logic [RW-1:0]               src2_reg,
    input logic                        dst_en,
    input logic [RW-1:0]               dst_reg,
    input logic                        cmt_valid,
    input logic [RW-1:0]               cmt_reg,
    input logic                        ckpt_restore,
    input logic [NUM_REGS-1:0][EW-1:0] live_entry,
    input logic [NUM_REGS-1:0][1:0]    live_slot,
    input logic [NUM_REGS-1:0]         live_busy,
    input logic [NUM_REGS-1:0][EW-1:0] live_writer,
    input logic [NUM_REGS-1:0]         snap_busy
);
    // R2: a producer starts a new chain at its destination slot.
    a_r2_writer_starts_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !ckpt_restore && dst_en) |=>
        (live_busy[$past(dst_reg)] && live_writer[$past(dst_reg)] == $past(dec_entry)
         && live_slot[$past(dst_reg)] == 2'd0));

    // R3: a reader of a busy register becomes the tail at source slot 1.
    a_r3_reader_appends: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !ckpt_restore && src1_en && src1_busy
         && !(src2_en && src2_reg == src1_reg) && !(dst_en && dst_reg == src1_reg)) |=>
        (live_entry[$past(src1_reg)] == $past(dec_entry) && live_slot[$past(src1_reg)] == 2'd1));

    // R4: a ready source leaves its row untouched.
    a_r4_ready_source_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !ckpt_restore && src1_en && !src1_busy
         && !(src2_en && src2_reg == src1_reg) && !(dst_en && dst_reg == src1_reg)
         && !(cmt_valid && cmt_reg == src1_reg)) |=>
        (live_entry[$past(src1_reg)] == $past(live_entry[src1_reg])
         && live_busy[$past(src1_reg)] == $past(live_busy[src1_reg])));

    // R8: a new producer wins over a same-cycle commit.
    a_r8_writer_beats_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !ckpt_restore && dst_en && cmt_valid && cmt_reg == dst_reg) |=>
        live_busy[$past(dst_reg)]);

    // R10: a restore without a commit loads the snapshot busy flags exactly.
    a_r10_restore_loads_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_restore && !cmt_valid) |=> (live_busy == $past(snap_busy)));
endmodule

bind consumer_table ct_checker #(.NUM_REGS(NUM_REGS), .EW(EW), .RW(RW)) u_ct_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_valid    (dec_valid),
    .dec_entry    (dec_entry),
    .src1_en      (src1_en),
    .src1_reg     (src1_reg),
    .src1_busy    (src1_busy),
    .src2_en      (src2_en),
    .src2_reg     (src2_reg),
    .dst_en       (dst_en),
    .dst_reg      (dst_reg),
    .cmt_valid    (cmt_valid),
    .cmt_reg      (cmt_reg),
    .ckpt_restore (ckpt_restore),
    .live_entry   (live_entry),
    .live_slot    (live_slot),
    .live_busy    (live_busy),
    .live_writer  (live_writer),
    .snap_busy    (snap_busy)
);

// File: tb/consumer_table_bench.sv
// Bench for consumer_table: a vector table walked cycle by cycle, then
// directed reset and checkpoint sequences.
module consumer_table_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;
    localparam int QD = 64;
    localparam int EW = $clog2(QD);
    localparam int RW = $clog2(NR);

    typedef struct packed {
        logic dv; logic [5:0] ent;
        logic s1e; logic [3:0] s1r;
        logic s2e; logic [3:0] s2r;
        logic de; logic [3:0] dr;
        logic cv; logic [5:0] ce; logic [3:0] cr;
        logic eb1; logic [5:0] ee1; logic [1:0] es1;
        logic eb2; logic [5:0] ee2; logic [1:0] es2;
    } vec_t;

    // Slot codes: 0 destination, 1 source 1, 2 source 2.
    localparam vec_t VECS [11] = '{
        '{0,0, 1,3, 1,4, 0,0, 0,0,0, 0,0,0, 0,0,0},  // R1 empty table
        '{1,1, 1,1, 0,0, 1,3, 0,0,0, 0,0,0, 0,0,0},  // R2 producer of r3, R4 r1 ready
        '{1,2, 1,3, 1,5, 1,4, 0,0,0, 1,1,0, 0,0,0},  // R3 append to r3
        '{1,3, 1,4, 1,3, 0,0, 0,0,0, 1,2,0, 1,2,1},  // R3 both sources append
        '{1,4, 1,3, 1,3, 0,0, 0,0,0, 1,3,2, 1,4,1},  // R6 same register twice
        '{1,5, 1,4, 0,0, 1,4, 0,0,0, 1,3,1, 0,0,0},  // R5 read and write r4
        '{0,0, 1,3, 1,4, 0,0, 1,2,4, 1,4,2, 1,5,0},  // R7 stale commit on r4
        '{0,0, 1,4, 0,0, 0,0, 1,1,3, 1,5,0, 0,0,0},  // R7 matching commit on r3
        '{1,6, 1,3, 1,4, 1,4, 1,5,4, 0,0,0, 1,5,0},  // R8 commit and new producer
        '{0,0, 1,4, 0,0, 0,0, 1,6,4, 1,6,0, 0,0,0},  // R8 r4 still busy
        '{0,0, 1,4, 1,3, 0,0, 0,0,0, 0,0,0, 0,0,0}   // R7 both retired
    };

    function automatic string vec_req(int i);
        case (i)
            0: return "R1";  1: return "R2";  2: return "R3";  3: return "R3";
            4: return "R6";  5: return "R5";  6: return "R7";  7: return "R7";
            8: return "R8";  9: return "R8";  default: return "R7";
        endcase
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 0, src1_en = 0, src2_en = 0, dst_en = 0;
    logic cmt_valid = 0, ckpt_take = 0, ckpt_restore = 0;
    logic [EW-1:0] dec_entry = '0, cmt_entry = '0;
    logic [RW-1:0] src1_reg = '0, src2_reg = '0, dst_reg = '0, cmt_reg = '0;
    logic src1_busy, src2_busy;
    logic [EW-1:0] src1_tail_entry, src2_tail_entry;
    logic [1:0] src1_tail_slot, src2_tail_slot;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    consumer_table #(.NUM_REGS(NR), .QUEUE_DEPTH(QD)) u_consumer_table (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_entry(dec_entry),
        .src1_en(src1_en), .src1_reg(src1_reg),
        .src2_en(src2_en), .src2_reg(src2_reg),
        .dst_en(dst_en), .dst_reg(dst_reg),
        .src1_busy(src1_busy), .src1_tail_entry(src1_tail_entry), .src1_tail_slot(src1_tail_slot),
        .src2_busy(src2_busy), .src2_tail_entry(src2_tail_entry), .src2_tail_slot(src2_tail_slot),
        .cmt_valid(cmt_valid), .cmt_entry(cmt_entry), .cmt_reg(cmt_reg),
        .ckpt_take(ckpt_take), .ckpt_restore(ckpt_restore)
    );

    task automatic check(string req, string what, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        dec_valid = 0; src1_en = 0; src2_en = 0; dst_en = 0;
        cmt_valid = 0; ckpt_take = 0; ckpt_restore = 0;
    endtask

    task automatic drive(logic dv, logic [5:0] e, logic s1e, logic [3:0] s1r,
                         logic s2e, logic [3:0] s2r, logic de, logic [3:0] dr);
        dec_valid = dv; dec_entry = e; src1_en = s1e; src1_reg = s1r;
        src2_en = s2e; src2_reg = s2r; dst_en = de; dst_reg = dr;
    endtask

    // Lookup of one register through source 1, checked before the next edge.
    task automatic probe(string req, logic [3:0] r, logic [8:0] exp);
        @(negedge clk);
        idle();
        src1_en = 1; src1_reg = r;
        #1;
        check(req, "probe", {src1_busy, src1_tail_entry, src1_tail_slot}, exp);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: every register reads ready after reset; disabled source reads zero.
        for (int r = 0; r < NR; r++) probe("R1", 4'(r), 9'h0);
        @(negedge clk);
        idle(); src2_en = 0; #1;
        check("R1", "disabled src2", {src2_busy, src2_tail_entry, src2_tail_slot}, 9'h0);

        // Vector walk: inputs at negedge, outputs checked before the edge.
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            drive(VECS[i].dv, VECS[i].ent, VECS[i].s1e, VECS[i].s1r,
                  VECS[i].s2e, VECS[i].s2r, VECS[i].de, VECS[i].dr);
            cmt_valid = VECS[i].cv; cmt_entry = VECS[i].ce; cmt_reg = VECS[i].cr;
            ckpt_take = 0; ckpt_restore = 0;
            #1;
            check(vec_req(i), $sformatf("vec %0d src1", i),
                  {src1_busy, src1_tail_entry, src1_tail_slot},
                  {VECS[i].eb1, VECS[i].ee1, VECS[i].es1});
            check(vec_req(i), $sformatf("vec %0d src2", i),
                  {src2_busy, src2_tail_entry, src2_tail_slot},
                  {VECS[i].eb2, VECS[i].ee2, VECS[i].es2});
        end

        // R9/R10: checkpoint includes same-cycle producer, restore drops later work.
        @(negedge clk); idle();
        drive(1, 6'd10, 0, 0, 0, 0, 1, 4'd7); ckpt_take = 1;
        @(negedge clk); idle();
        drive(1, 6'd11, 1, 4'd7, 0, 0, 1, 4'd8);
        @(negedge clk); idle();
        drive(1, 6'd12, 0, 0, 0, 0, 1, 4'd9); ckpt_restore = 1;
        probe("R9", 4'd7, {1'b1, 6'd10, 2'd0});
        probe("R9", 4'd8, 9'h0);
        probe("R10", 4'd9, 9'h0);

        // R11: a producer captured in the snapshot retires before the restore.
        @(negedge clk); idle();
        drive(1, 6'd20, 0, 0, 0, 0, 1, 4'd2); ckpt_take = 1;
        @(negedge clk); idle();
        cmt_valid = 1; cmt_entry = 6'd20; cmt_reg = 4'd2;
        @(negedge clk); idle(); ckpt_restore = 1;
        probe("R11", 4'd2, 9'h0);
        probe("R11", 4'd7, {1'b1, 6'd10, 2'd0});

        // R7: a commit with a different register leaves r7 busy.
        @(negedge clk); idle();
        cmt_valid = 1; cmt_entry = 6'd10; cmt_reg = 4'd6;
        probe("R7", 4'd7, {1'b1, 6'd10, 2'd0});

        @(negedge clk); idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule